// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels may run its next transfer. Each channel raises a request line. While no transfer is in flight and the controller is enabled, the arbiter picks one requester and holds a one-hot grant until the transfer engine strobes completion. Only then does it make the next decision. A 2-bit mode field selects one of three fixed priority orders or a rotating order in which the channel that just finished drops to the back.

The block also holds a sticky address-error flag. The transfer engine sets it with a pulse. While the flag is set, the in-flight grant is withdrawn, no new grant is issued, the global transfer-enable output is low and the error interrupt is raised. Software cannot set the flag. Software clears it only by reading the register while the flag shows 1 and then writing 0 to the flag bit. A single control/status register, reached through a plain read/write strobe port, carries the mode field and the flag.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, grant is 0000, grant_vld is 0, xfer_en is 1, err_irq is 0 and reg_rdata reads 0 (mode code 00, flag clear).
- R2: With mode code 00, the fixed order is channel 0 first, then 1, then 2, then 3.
- R3: With mode code 01, the fixed order is channel 0 first, then 2, then 3, then 1.
- R4: With mode code 10, the fixed order is channel 2 first, then 0, then 1, then 3.
- R5: With mode code 11, the order rotates. It starts as 0, 1, 2, 3 after reset. When a transfer completes in this mode, the finishing channel moves to last place and the others keep their relative order.
- R6: A decision is taken only in an idle cycle with the flag clear and at least one request. The one-hot grant and grant_vld appear on the next cycle. They stay unchanged until a cycle with xfer_done, and are 0 from the cycle after it.
- R7: A mode write takes effect at the next decision. It never changes or withdraws a grant already held.
- R8: An addr_err pulse sets the flag on the next cycle and withdraws any held grant. While the flag is set, no grant is issued, xfer_en is 0 and err_irq is 1.
- R9: Writing 1 to the flag bit never sets the flag. Writing 0 to it without a preceding read that returned the flag as 1 leaves it set.
- R10: A read that returns the flag as 1 arms a clear. The next write consumes the arm, and clears the flag only if it writes 0 to bit 4.
- R11: Register layout: bits [1:0] hold the mode code and bit 4 the flag. Every other bit reads 0, and writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Transfer request, one bit per channel |
| xfer_done | input | 1 | Strobe: the granted transfer has completed |
| addr_err | input | 1 | Strobe: the transfer engine hit an address error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register contents (mode [1:0], flag [4]) |
| grant | output | 4 | One-hot grant to the winning channel |
| grant_vld | output | 1 | A grant is currently held |
| xfer_en | output | 1 | Global transfer enable (low while the flag is set) |
| err_irq | output | 1 | Error interrupt request |

## Verification
Each mode is exercised with all four requests held high, which shows the head of its order, and with random request nibbles, which show how it ranks every pair of channels. Single rotating requests isolate grant hold and release timing. Completions arriving after random delays exercise the rotation of the round-robin order. Mode writes issued while a grant is held separate deferred mode changes from preemption. The register sequences put a write-1, a write-0 without a read, a write-1 that consumes the arm, and a real read-then-write-0 side by side, so an arm that is ignored, never consumed or wrongly granted shows up in the flag.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NCH = 4;
    localparam int IDW = $clog2(NCH);

    typedef logic [IDW-1:0] ch_id_t;
    typedef ch_id_t [NCH-1:0] order_t;   // index 0 = highest priority

    typedef enum logic [1:0] {
        PM_LINEAR    = 2'b00,
        PM_SKIP1     = 2'b01,
        PM_CH2_FIRST = 2'b10,
        PM_ROTATE    = 2'b11
    } prio_mode_e;

    typedef struct packed {
        logic       busy;
        ch_id_t     owner;
        order_t     order;
    } core_st_t;

    typedef struct packed {
        prio_mode_e mode;
        logic       err;
        logic       armed;
    } csr_st_t;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
(
    input  prio_mode_e         mode,
    input  order_t             rr_order,
    input  logic [NCH-1:0]     req,
    output logic               hit,
    output ch_id_t             win
);
    order_t seq;

    always_comb begin
        case (mode)
            PM_LINEAR:    seq = {2'd3, 2'd2, 2'd1, 2'd0};
            PM_SKIP1:     seq = {2'd1, 2'd3, 2'd2, 2'd0};
            PM_CH2_FIRST: seq = {2'd3, 2'd1, 2'd0, 2'd2};
            default:      seq = rr_order;
        endcase
    end

    // walk from lowest to highest priority so the highest match is kept
    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[seq[i]]) begin
                hit = 1'b1;
                win = seq[i];
            end
        end
    end
endmodule

// File: rtl/dma_arb_core.sv
module dma_arb_core
    import dma_arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           xfer_done,
    input  logic           addr_err,
    input  logic           halt,
    input  prio_mode_e     mode,
    output logic [NCH-1:0] grant,
    output logic           grant_vld
);
    core_st_t st_d, st_q;
    logic     pick_hit;
    ch_id_t   pick_win;

    dma_arb_pick u_pick (
        .mode     (mode),
        .rr_order (st_q.order),
        .req      (req),
        .hit      (pick_hit),
        .win      (pick_win)
    );

    always_comb begin
        order_t         nxt_order;
        logic [IDW:0]   pos;
        st_d      = st_q;
        nxt_order = st_q.order;
        pos       = '0;
        for (int i = 0; i < NCH; i++) begin
            if (st_q.order[i] != st_q.owner) begin
                nxt_order[pos[IDW-1:0]] = st_q.order[i];
                pos = pos + 1'b1;
            end
        end
        nxt_order[NCH-1] = st_q.owner;

        if (addr_err) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            if (xfer_done) begin
                st_d.busy = 1'b0;
                if (mode == PM_ROTATE) st_d.order = nxt_order;
            end
        end else if (!halt && pick_hit) begin
            st_d.busy  = 1'b1;
            st_d.owner = pick_win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.owner <= '0;
            for (int i = 0; i < NCH; i++) st_q.order[i] <= ch_id_t'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant     = st_q.busy ? (NCH'(1) << st_q.owner) : '0;
    assign grant_vld = st_q.busy;

    // R6: grant held until completion
    assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld && !xfer_done && !addr_err |=> grant_vld && $stable(grant));
    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_vld == (grant != '0)));
    // R8: no new grant while the error flag is set
    assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !grant_vld |=> !grant_vld);
    assert_err_drops_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> !grant_vld);
    // R5: rotating order remains a permutation of the channels
    assert_order_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({(st_q.order[0] == 2'd0) || (st_q.order[1] == 2'd0) || (st_q.order[2] == 2'd0) || (st_q.order[3] == 2'd0),
                    (st_q.order[0] == 2'd1) || (st_q.order[1] == 2'd1) || (st_q.order[2] == 2'd1) || (st_q.order[3] == 2'd1),
                    (st_q.order[0] == 2'd2) || (st_q.order[1] == 2'd2) || (st_q.order[2] == 2'd2) || (st_q.order[3] == 2'd2),
                    (st_q.order[0] == 2'd3) || (st_q.order[1] == 2'd3) || (st_q.order[2] == 2'd3) || (st_q.order[3] == 2'd3)}) == NCH);
endmodule

// File: rtl/dma_arb_csr.sv
module dma_arb_csr
    import dma_arb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MODE_LSB = 0,
    parameter int ERR_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              addr_err,
    output logic [DATA_W-1:0] rdata,
    output prio_mode_e        mode,
    output logic              err_flag
);
    csr_st_t st_d, st_q;
    logic    wdata_unused;

    assign wdata_unused = ^wdata;

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            st_d.mode = prio_mode_e'(wdata[MODE_LSB +: 2]);
            if (st_q.armed && !wdata[ERR_BIT]) st_d.err = 1'b0;
            st_d.armed = 1'b0;
        end
        if (reg_rd && st_q.err) st_d.armed = 1'b1;
        if (addr_err) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= PM_LINEAR;
            st_q.err   <= 1'b0;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata                  = '0;
        rdata[MODE_LSB +: 2]   = st_q.mode;
        rdata[ERR_BIT]         = st_q.err;
    end

    assign mode     = st_q.mode;
    assign err_flag = st_q.err;

    // R9: software alone never raises the flag
    assert_no_sw_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag && !addr_err |=> !err_flag);
    // R8: flag is sticky without a register write
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !reg_wr |=> err_flag);
    // R10: a clear needs an armed write
    assert_clear_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $past(reg_wr) && $past(st_q.armed));
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MODE_LSB = 0,
    parameter int ERR_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req,
    input  logic              xfer_done,
    input  logic              addr_err,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    grant,
    output logic              grant_vld,
    output logic              xfer_en,
    output logic              err_irq
);
    prio_mode_e mode;
    logic       err_flag;

    dma_arb_csr #(
        .DATA_W   (DATA_W),
        .MODE_LSB (MODE_LSB),
        .ERR_BIT  (ERR_BIT)
    ) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .wdata    (reg_wdata),
        .addr_err (addr_err),
        .rdata    (reg_rdata),
        .mode     (mode),
        .err_flag (err_flag)
    );

    dma_arb_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .xfer_done (xfer_done),
        .addr_err  (addr_err),
        .halt      (err_flag),
        .mode      (mode),
        .grant     (grant),
        .grant_vld (grant_vld)
    );

    assign xfer_en = !err_flag;
    assign err_irq = err_flag;

    // R8: interrupt only follows a reported error
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> $past(addr_err));
endmodule

// File: tb/dma_prio_arb_bench.sv
module dma_prio_arb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic        xfer_done = 1'b0;
    logic        addr_err = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  grant;
    logic        grant_vld;
    logic        xfer_en;
    logic        err_irq;

    always #2.5 clk = ~clk;

    dma_prio_arb u_dma_prio_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
        .addr_err(addr_err), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grant(grant),
        .grant_vld(grant_vld), .xfer_en(xfer_en), .err_irq(err_irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    n_cyc = 0;
    bit    live = 1'b0;
    bit    ended = 1'b0;
    string tag = "R1";

    // behavioural reference model
    int m_busy, m_own, m_err, m_arm, m_mode;
    int rr[$];

    function automatic int pick(logic [3:0] r);
        int seq[4];
        case (m_mode)
            0: seq = '{0, 1, 2, 3};
            1: seq = '{0, 2, 3, 1};
            2: seq = '{2, 0, 1, 3};
            default: for (int i = 0; i < 4; i++) seq[i] = rr[i];
        endcase
        for (int i = 0; i < 4; i++) if (r[seq[i]]) return seq[i];
        return 0;
    endfunction

    always @(posedge clk) begin
        int n_err, n_arm, n_mode;
        n_cyc++;
        if (!rst_n) begin
            m_busy = 0; m_own = 0; m_err = 0; m_arm = 0; m_mode = 0;
            rr = '{0, 1, 2, 3};
        end else begin
            n_err = m_err; n_arm = m_arm; n_mode = m_mode;
            if (reg_wr) begin
                n_mode = int'(reg_wdata[1:0]);
                if (m_arm != 0 && !reg_wdata[4]) n_err = 0;
                n_arm = 0;
            end
            if (reg_rd && m_err != 0) n_arm = 1;
            if (addr_err) n_err = 1;
            if (addr_err) m_busy = 0;
            else if (m_busy != 0) begin
                if (xfer_done) begin
                    m_busy = 0;
                    if (m_mode == 3) begin
                        for (int k = 0; k < 4; k++) if (rr[k] == m_own) begin rr.delete(k); break; end
                        rr.push_back(m_own);
                    end
                end
            end else if (m_err == 0 && req != 4'b0) begin
                m_busy = 1;
                m_own  = pick(req);
            end
            m_err = n_err; m_arm = n_arm; m_mode = n_mode;
        end
    end

    task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [3:0]  e_gnt;
        logic [15:0] e_rd;
        if (live) begin
            e_gnt = (m_busy != 0) ? 4'(1 << m_own) : 4'b0;
            e_rd  = 16'(m_mode) | (m_err != 0 ? 16'h0010 : 16'h0);
            chk({grant, grant_vld, xfer_en, err_irq, reg_rdata} ==
                {e_gnt, m_busy != 0, m_err == 0, m_err != 0, e_rd}, tag,
                {12'b0, grant, grant_vld, xfer_en, err_irq, reg_rdata},
                {12'b0, e_gnt, m_busy != 0, m_err == 0, m_err != 0, e_rd});
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) if (n_cyc > 50000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // kind 0: all requests, 1: random nibble, 2: walking single bit
    task automatic run(int n, int kind, bit allow_done);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reg_wr = 0; reg_rd = 0; addr_err = 0;
            case (kind)
                0: req = 4'hF;
                1: req = 4'($urandom_range(0, 15));
                default: req = 4'(1 << (i % 4));
            endcase
            xfer_done = allow_done && grant_vld && ($urandom_range(0, 2) == 0);
        end
    endtask

    task automatic wr(logic [15:0] d);
        @(negedge clk);
        req = 0; xfer_done = 0; addr_err = 0; reg_rd = 0;
        reg_wr = 1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd();
        @(negedge clk);
        req = 0; xfer_done = 0; addr_err = 0; reg_wr = 0;
        reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(grant == 4'b0 && !grant_vld, "R1", {28'b0, grant}, 32'h0);
        chk(xfer_en && !err_irq, "R1", {30'b0, xfer_en, err_irq}, 32'h2);
        chk(reg_rdata == 16'h0, "R1", {16'b0, reg_rdata}, 32'h0);
        live = 1'b1;

        tag = "R2"; wr(16'h0000); run(40, 0, 1); run(150, 1, 1);
        tag = "R6"; run(60, 2, 1);
        tag = "R3"; wr(16'h0001); run(40, 0, 1); run(150, 1, 1);
        tag = "R4"; wr(16'h0002); run(40, 0, 1); run(150, 1, 1);
        tag = "R5"; wr(16'h0003); run(60, 0, 1); run(250, 1, 1);

        // R7: mode writes during a held grant
        tag = "R7"; wr(16'h0000); run(3, 0, 0);
        wr(16'h0002); run(4, 0, 0); wr(16'h0003); run(30, 1, 1);

        // R8: error while a grant is held
        tag = "R8"; run(3, 0, 0);
        @(negedge clk); addr_err = 1; xfer_done = 0;
        run(20, 0, 1);

        // R9: writes without a read leave the flag
        tag = "R9"; wr(16'h0010); run(2, 0, 1); wr(16'h0000); run(4, 0, 1);

        // R10: arm consumed by a write of 1, then a real clear
        tag = "R10"; rd(); wr(16'h0011); run(3, 0, 1); wr(16'h0000); run(3, 0, 1);
        rd(); wr(16'h0002); run(30, 1, 1);

        // R11: reserved bits
        tag = "R11"; wr(16'hFFEE); run(5, 1, 1); wr(16'hFFFF); run(20, 1, 1);
        @(negedge clk); addr_err = 1; @(negedge clk); addr_err = 0;
        wr(16'hFFEF); rd(); wr(16'hFFE0); run(40, 1, 1);

        live = 1'b0;
        finish_run();
    end
endmodule